// File: doc/BRIEF.md
# Byte-Order Swap Execution Unit

This unit is one execution slot of a 64-bit integer pipeline. It takes a 32-bit instruction word together with the value of its one source operand. It recognises three byte-order swap operations. The first swaps the two bytes of every 16-bit lane. The second reverses the four bytes of every 32-bit lane. The third reverses all eight bytes of the operand. The unit returns the swapped value and the destination register index from the instruction, each registered, with a result strobe one clock later.

The unit reads no second operand and writes no condition or status state. An encoding it does not own raises a one-cycle illegal flag in place of a result. When that happens, the registered result and destination index keep their previous values. Register file reads and writes, exception handling and every other logical operation belong to neighbouring blocks.

Top module: `bswap_unit`

## Requirements
- R1: An accepted instruction with extended opcode 0b0011011011 (instruction bits [10:1], bit 0 being the least significant) produces the operand with the two bytes of each 16-bit lane exchanged; the lanes stay in place (0x0123456789ABCDEF gives 0x23016745AB89EFCD).
- R2: Extended opcode 0b0010011011 reverses the four bytes inside each 32-bit lane independently and leaves the two lanes in place (0x0123456789ABCDEF gives 0x67452301EFCDAB89).
- R3: Extended opcode 0b0010111011 reverses all eight bytes, so the most significant byte becomes the least significant (0xFEDCBA9876543210 gives 0x1032547698BADCFE).
- R4: An encoding is legal only when bits [31:26] equal 31, bits [15:11] are zero, bit [0] is zero and bits [10:1] hold one of the three opcodes above. The destination index output is taken from bits [20:16]. Bits [25:21] (the source index) have no effect on the output.
- R5: A valid input with any other encoding raises illegalOut for exactly the next cycle, and outValid stays low in that cycle. illegalOut and outValid are never high together.
- R6: outValid is high in the cycle after a legal valid input and in no other cycle. Without inValid, neither outValid nor illegalOut rises.
- R7: result and dstIdx change only in a cycle where outValid is high. Idle cycles and illegal inputs leave them unchanged.
- R8: A synchronous active-high reset clears outValid, illegalOut, result and dstIdx to zero.
- R9: Each of the three operations is its own inverse: feeding a result back in with the same opcode returns the original operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction and operand are presented this cycle |
| insn | input | 32 | Instruction word, bit 31 the most significant |
| operand | input | 64 | Source operand value |
| outValid | output | 1 | result and dstIdx carry a new result |
| result | output | 64 | Swapped operand |
| dstIdx | output | 5 | Destination register index |
| illegalOut | output | 1 | Previous valid input was not a recognised encoding |

## Verification
A wrong decode state shows up one clock after the input. It appears either as a result strobe where the illegal flag belongs, or as a missing strobe, so every sweep over opcode and reserved-field values is settled in one cycle per encoding. A wrong byte route shows up in that same cycle as a misplaced byte. A walking marker byte in each lane position, checked under all three modes, names the faulty byte. A load enable that fires at the wrong time shows up at the next idle or illegal cycle as a result or index that should have held its value.

// File: rtl/bswap_pkg.sv
package bswap_pkg;

  localparam int REG_IDX_W = 5;
  localparam int XO_W      = 10;
  localparam int PRIMARY_W = 6;

  localparam logic [PRIMARY_W-1:0] PRIMARY_EXT = 6'd31;
  localparam logic [XO_W-1:0] XO_SWAP_HALF   = 10'b0011011011;
  localparam logic [XO_W-1:0] XO_SWAP_WORD   = 10'b0010011011;
  localparam logic [XO_W-1:0] XO_SWAP_DOUBLE = 10'b0010111011;

  typedef enum logic [1:0] {
    SWAP_HALF   = 2'd0,
    SWAP_WORD   = 2'd1,
    SWAP_DOUBLE = 2'd2,
    SWAP_NONE   = 2'd3
  } swapMode_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic                 loadEn;
    swapMode_e            mode;
    logic [REG_IDX_W-1:0] dst;
  } swapCtrl_t;

endpackage

// File: rtl/bswap_ctrl.sv
module bswap_ctrl
  import bswap_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [INSN_W-1:0] insn,
  output swapCtrl_t         ctrl,
  output logic              validQ,
  output logic              illegalQ
);

  localparam int PO_LSB  = INSN_W - PRIMARY_W;
  localparam int RA_LSB  = PO_LSB - 2*REG_IDX_W;
  localparam int MID_LSB = RA_LSB - REG_IDX_W;

  logic [PRIMARY_W-1:0] primary;
  logic [REG_IDX_W-1:0] midField;
  logic [XO_W-1:0]      extOp;
  logic                 recBit;
  swapMode_e            mode;
  logic                 legal;

  assign primary  = insn[PO_LSB +: PRIMARY_W];
  assign midField = insn[MID_LSB +: REG_IDX_W];
  assign extOp    = insn[1 +: XO_W];
  assign recBit   = insn[0];

  always_comb begin
    unique case (extOp)
      XO_SWAP_HALF:   mode = SWAP_HALF;
      XO_SWAP_WORD:   mode = SWAP_WORD;
      XO_SWAP_DOUBLE: mode = SWAP_DOUBLE;
      default:        mode = SWAP_NONE;
    endcase
  end

  assign legal = (primary == PRIMARY_EXT) && (midField == '0) &&
                 !recBit && (mode != SWAP_NONE);

  assign ctrl.loadEn = inValid && legal;
  assign ctrl.mode   = mode;
  assign ctrl.dst    = insn[RA_LSB +: REG_IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ   <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      validQ   <= inValid && legal;
      illegalQ <= inValid && !legal;
    end
  end

endmodule

// File: rtl/bswap_datapath.sv
module bswap_datapath
  import bswap_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  swapCtrl_t            ctrl,
  input  logic [DATA_W-1:0]    operand,
  output logic [DATA_W-1:0]    resultQ,
  output logic [REG_IDX_W-1:0] dstQ
);

  localparam int N_BYTES   = DATA_W / BYTE_W;
  localparam int HALF_SPAN = 2;
  localparam int WORD_SPAN = 4;

  logic [DATA_W-1:0] halfSwap;
  logic [DATA_W-1:0] wordSwap;
  logic [DATA_W-1:0] fullSwap;
  logic [DATA_W-1:0] swapped;

  // Each destination byte picks its source byte inside its lane
  for (genvar b = 0; b < N_BYTES; b++) begin : gLane
    localparam int HALF_SRC = (b / HALF_SPAN) * HALF_SPAN + (HALF_SPAN - 1 - b % HALF_SPAN);
    localparam int WORD_SRC = (b / WORD_SPAN) * WORD_SPAN + (WORD_SPAN - 1 - b % WORD_SPAN);
    localparam int FULL_SRC = N_BYTES - 1 - b;
    assign halfSwap[b*BYTE_W +: BYTE_W] = operand[HALF_SRC*BYTE_W +: BYTE_W];
    assign wordSwap[b*BYTE_W +: BYTE_W] = operand[WORD_SRC*BYTE_W +: BYTE_W];
    assign fullSwap[b*BYTE_W +: BYTE_W] = operand[FULL_SRC*BYTE_W +: BYTE_W];
  end

  always_comb begin
    unique case (ctrl.mode)
      SWAP_HALF:   swapped = halfSwap;
      SWAP_WORD:   swapped = wordSwap;
      SWAP_DOUBLE: swapped = fullSwap;
      default:     swapped = operand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultQ <= '0;
      dstQ    <= '0;
    end else if (ctrl.loadEn) begin
      resultQ <= swapped;
      dstQ    <= ctrl.dst;
    end
  end

endmodule

// File: rtl/bswap_unit.sv
module bswap_unit
  import bswap_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int INSN_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [INSN_W-1:0]    insn,
  input  logic [DATA_W-1:0]    operand,
  output logic                 outValid,
  output logic [DATA_W-1:0]    result,
  output logic [REG_IDX_W-1:0] dstIdx,
  output logic                 illegalOut
);

  swapCtrl_t ctrl;

  bswap_ctrl #(.INSN_W(INSN_W)) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .insn(insn),
    .ctrl(ctrl), .validQ(outValid), .illegalQ(illegalOut)
  );

  bswap_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) uPath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .operand(operand),
    .resultQ(result), .dstQ(dstIdx)
  );

endmodule

// File: rtl/bswap_unit_chk.sv
module bswap_unit_chk #(
  parameter int DATA_W = 64,
  parameter int INSN_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [INSN_W-1:0] insn,
  input logic [DATA_W-1:0] operand,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic [4:0]        dstIdx,
  input logic              illegalOut
);

  AST_NO_BOTH_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !(outValid && illegalOut)); // R5

  AST_ILLEGAL_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
    illegalOut |-> $past(inValid)); // R5

  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid)); // R6

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(result) && $stable(dstIdx))); // R7

  AST_HALF_LOW_LANE: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(insn[10:1]) == 10'b0011011011) |->
      result[15:8] == $past(operand[7:0])); // R1

  AST_WORD_LOW_LANE: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(insn[10:1]) == 10'b0010011011) |->
      result[31:24] == $past(operand[7:0])); // R2

  AST_DOUBLE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(insn[10:1]) == 10'b0010111011) |->
      result[7:0] == $past(operand[DATA_W-1 -: 8])); // R3

  AST_DST_FIELD: assert property (@(posedge clk) disable iff (rst)
    outValid |-> dstIdx == $past(insn[20:16])); // R4

endmodule

bind bswap_unit bswap_unit_chk #(.DATA_W(DATA_W), .INSN_W(INSN_W)) uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .insn(insn), .operand(operand),
  .outValid(outValid), .result(result), .dstIdx(dstIdx), .illegalOut(illegalOut)
);

// File: tb/tb_bswap_unit.sv
module tb_bswap_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] operand = '0;
  logic        outValid;
  logic [63:0] result;
  logic [4:0]  dstIdx;
  logic        illegalOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  localparam logic [9:0] XO_H = 10'b0011011011;
  localparam logic [9:0] XO_W = 10'b0010011011;
  localparam logic [9:0] XO_D = 10'b0010111011;

  always #2 clk = ~clk;

  bswap_unit dut (
    .clk(clk), .rst(rst), .inValid(inValid), .insn(insn), .operand(operand),
    .outValid(outValid), .result(result), .dstIdx(dstIdx), .illegalOut(illegalOut)
  );

  function automatic logic [31:0] mkInsn(input logic [5:0] po, input logic [4:0] rs,
      input logic [4:0] ra, input logic [4:0] mid, input logic [9:0] xo, input logic rc);
    return {po, rs, ra, mid, xo, rc};
  endfunction

  // Reference: destination byte i comes from source byte i XOR (lane bytes - 1)
  function automatic logic [63:0] refSwap(input logic [9:0] xo, input logic [63:0] v);
    int mask;
    logic [63:0] r;
    mask = (xo == XO_H) ? 1 : (xo == XO_W) ? 3 : 7;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = v[(i ^ mask)*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive for one cycle at the falling edge; outputs are read one cycle later
  task automatic issue(input logic [31:0] w, input logic [63:0] v);
    insn = w; operand = v; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runLegal(input string req, input logic [9:0] xo, input logic [4:0] ra,
      input logic [63:0] v);
    issue(mkInsn(6'd31, 5'd4, ra, 5'd0, xo, 1'b0), v);
    check(req, {63'd0, outValid}, 64'd1);
    check(req, {63'd0, illegalOut}, 64'd0);
    check(req, result, refSwap(xo, v));
    check("R4", {59'd0, dstIdx}, {59'd0, ra});
  endtask

  task automatic runIllegal(input string req, input logic [31:0] w);
    logic [63:0] prevRes;
    logic [4:0]  prevDst;
    prevRes = result; prevDst = dstIdx;
    issue(w, 64'hA5A5_5A5A_0F0F_F0F0);
    check(req, {62'd0, outValid, illegalOut}, 64'd1);
    check("R7", result, prevRes);
    check("R7", {59'd0, dstIdx}, {59'd0, prevDst});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun + 1, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [9:0] xos [3];
    logic [63:0] once;
    xos[0] = XO_H; xos[1] = XO_W; xos[2] = XO_D;
    repeat (3) @(negedge clk);
    // R8: reset state, with inputs driven during reset
    inValid = 1'b1; insn = mkInsn(6'd31, 5'd1, 5'd9, 5'd0, XO_D, 1'b0); operand = '1;
    @(negedge clk);
    check("R8", {62'd0, outValid, illegalOut}, 64'd0);
    check("R8", result, 64'd0);
    check("R8", {59'd0, dstIdx}, 64'd0);
    inValid = 1'b0; rst = 1'b0;
    @(negedge clk);
    check("R6", {62'd0, outValid, illegalOut}, 64'd0);

    // Fixed vectors
    runLegal("R1", XO_H, 5'd3, 64'h0123456789ABCDEF);
    check("R1", result, 64'h23016745AB89EFCD);
    runLegal("R2", XO_W, 5'd3, 64'h0123456789ABCDEF);
    check("R2", result, 64'h67452301EFCDAB89);
    runLegal("R3", XO_D, 5'd3, 64'h0123456789ABCDEF);
    check("R3", result, 64'hEFCDAB8967452301);
    runLegal("R1", XO_H, 5'd3, 64'hFEDCBA9876543210);
    check("R1", result, 64'hDCFE98BA54761032);
    runLegal("R2", XO_W, 5'd3, 64'hFEDCBA9876543210);
    check("R2", result, 64'h98BADCFE10325476);
    runLegal("R3", XO_D, 5'd3, 64'hFEDCBA9876543210);
    check("R3", result, 64'h1032547698BADCFE);

    // Walking marker byte in every position, every mode
    for (int m = 0; m < 3; m++)
      for (int p = 0; p < 8; p++)
        runLegal(m == 0 ? "R1" : m == 1 ? "R2" : "R3", xos[m], 5'(p),
                 64'h11 << (p*8) | 64'hC3 << (((p+1)%8)*8));

    // Random operands and involution
    for (int k = 0; k < 200; k++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      for (int m = 0; m < 3; m++) begin
        runLegal(m == 0 ? "R1" : m == 1 ? "R2" : "R3", xos[m], 5'(k), v);
        once = result;
        runLegal("R9", xos[m], 5'(k + 1), once);
        check("R9", result, v);
      end
    end

    // R4: source index field has no effect; every destination index
    for (int i = 0; i < 32; i++) begin
      issue(mkInsn(6'd31, 5'(31 - i), 5'(i), 5'd0, XO_W, 1'b0), 64'h0011223344556677);
      check("R4", result, 64'h3322110077665544);
      check("R4", {59'd0, dstIdx}, {59'd0, 5'(i)});
    end

    // R5: full sweep of extended opcodes under primary 31
    for (int x = 0; x < 1024; x++) begin
      if (10'(x) == XO_H || 10'(x) == XO_W || 10'(x) == XO_D)
        runLegal("R4", 10'(x), 5'd7, 64'h8877665544332211);
      else
        runIllegal("R5", mkInsn(6'd31, 5'd4, 5'd8, 5'd0, 10'(x), 1'b0));
    end
    // R5: every other primary opcode, reserved field bits, record bit
    for (int p = 0; p < 64; p++)
      if (p != 31) runIllegal("R5", mkInsn(6'(p), 5'd4, 5'd8, 5'd0, XO_D, 1'b0));
    for (int b = 0; b < 5; b++)
      runIllegal("R5", mkInsn(6'd31, 5'd4, 5'd8, 5'(1 << b), XO_H, 1'b0));
    runIllegal("R5", mkInsn(6'd31, 5'd4, 5'd8, 5'd0, XO_W, 1'b1));

    // R6/R7: idle cycles raise nothing and hold the result
    runLegal("R3", XO_D, 5'd21, 64'hDEADBEEF01234567);
    once = result;
    insn = mkInsn(6'd31, 5'd4, 5'd2, 5'd0, XO_H, 1'b0); operand = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R6", {62'd0, outValid, illegalOut}, 64'd0);
      check("R7", result, once);
      check("R7", {59'd0, dstIdx}, 64'd21);
    end

    // Back-to-back inputs, one result per cycle
    insn = mkInsn(6'd31, 5'd4, 5'd1, 5'd0, XO_H, 1'b0); operand = 64'h0102030405060708;
    inValid = 1'b1;
    @(negedge clk);
    insn = mkInsn(6'd31, 5'd4, 5'd2, 5'd0, XO_D, 1'b0);
    check("R6", {62'd0, outValid, illegalOut}, 64'd2);
    check("R1", result, 64'h0201040306050807);
    @(negedge clk);
    inValid = 1'b0;
    check("R6", {62'd0, outValid, illegalOut}, 64'd2);
    check("R3", result, 64'h0807060504030201);
    @(negedge clk);
    check("R6", {62'd0, outValid, illegalOut}, 64'd0);

    // R8: mid-run reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8", result, 64'd0);
    check("R8", {59'd0, dstIdx}, 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule